// File: doc/BRIEF.md
# UART Receiver with RTS Flow Control

This block is the receive side of an asynchronous serial port. It oversamples the serial line and turns each frame into a byte: one start bit, eight data bits sent least significant bit first, and one stop bit. Each byte goes into a three-entry queue, and the host takes bytes from the queue through a read strobe. The output at the head of the queue is valid whenever the queue is non-empty. The block also drives a request-to-send line toward the far transmitter. When the queue is full and another frame begins, the block drops this line so that the sender stops before data is lost.

The host controls the block through a single command strobe. One command enables the receiver and another disables it. A third command resets the receive path. A fourth command asserts request-to-send and hands the line over to automatic control. The commands differ in what they do to stored bytes and to a byte that is partly received. Disabling keeps the bytes already in the queue readable. It throws away a frame that is still arriving and a byte that is waiting for queue space. A reset throws away everything.

When the queue is full, a completed byte waits in the shift stage. If another start bit is confirmed before that byte can move into the queue, the waiting byte is lost and a sticky overrun flag is set.

Top module: `uart_rx_rts`

## Requirements
- R1: After rst_ni is released, all of the following are 0: rxrdy_o, ffull_o, ovr_o, irq_o and rts_o. The receiver starts disabled.
- R2: A sample is taken on each cycle where os_tick_i is high, at OSR samples per bit. A start bit is accepted only if the line is still low OSR/2 samples after the first low sample. A shorter low pulse produces no byte.
- R3: Data bits are sampled at bit centre and assembled least significant bit first. Bytes are read in arrival order. rd_data_o shows the oldest stored byte, and a pulse on rd_i while rxrdy_o is 1 removes that byte.
- R4: rxrdy_o is 1 whenever the queue holds at least one byte. ffull_o is 1 when all DEPTH entries are in use.
- R5: irq_o is 1 exactly when rxrdy_o and irq_en_i are both 1. It falls when the queue is drained or the receive path is reset.
- R6: Command code 4 (cmd_valid_i high, cmd_i = 3'd4) sets rts_o to 1 and hands the line to automatic control. Before that command, rts_o stays 0. Under automatic control, rts_o falls when a start bit is confirmed while the queue is full, and it returns to 1 on the next read.
- R7: A byte that completes while the queue is full waits in the shift stage and enters the queue as soon as an entry is freed. If a start bit is confirmed while a byte is waiting, the waiting byte is lost and ovr_o is set. ovr_o then stays set until a reset command.
- R8: Command code 1 enables the receiver and code 2 disables it. While the receiver is disabled, bytes already queued stay readable and frames on the line are not stored.
- R9: A disable command issued while a frame is arriving discards that frame. The frame is not stored, even after the receiver is enabled again.
- R10: A disable command issued while a completed byte waits for queue space discards that byte.
- R11: Command code 3 empties the queue and clears ovr_o, irq_o and rts_o. It also disables the receiver and returns rts_o to host control, so rts_o stays 0 until code 4 is issued again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| os_tick_i | input | 1 | Oversampling enable, OSR pulses per bit |
| rxd_i | input | 1 | Serial input, idle high |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code: 1 enable, 2 disable, 3 reset, 4 assert RTS |
| irq_en_i | input | 1 | Interrupt enable for receiver-ready |
| rd_i | input | 1 | Read strobe, removes the head byte |
| rd_data_o | output | DATA_W | Oldest stored byte |
| rxrdy_o | output | 1 | Queue not empty |
| ffull_o | output | 1 | Queue full |
| ovr_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Interrupt request |
| rts_o | output | 1 | Request-to-send, high means ready to receive |

## Verification
The bench builds the block with its default values: DATA_W of 8, OSR of 16 and a queue DEPTH of 3. os_tick_i is held high, so every clock is a sample and a whole frame takes 160 cycles. With only three entries, four frames in a row fill the queue and park a byte in the shift stage. A fifth frame then overwrites the parked byte. This reaches the full flag, the request-to-send drop and its recovery on a read, and the overrun path quickly. It also makes it easy to disable the receiver mid-frame or while a byte is parked.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_EN     = 3'd1,
    CMD_DIS    = 3'd2,
    CMD_RST    = 3'd3,
    CMD_RTS_ON = 3'd4
  } rx_cmd_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_STOP
  } deser_state_e;
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              rxd_i,
  output logic              start_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OSR / 2 - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  logic [1:0]        sync_q;
  logic              rxd_s;
  deser_state_e      st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;

  assign rxd_s  = sync_q[1];
  assign data_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      start_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      start_o <= 1'b0;
      done_o  <= 1'b0;
      if (!run_i) begin
        // disabled: abandon any frame in progress
        st_q  <= S_IDLE;
        cnt_q <= '0;
        bit_q <= '0;
      end else if (tick_i) begin
        unique case (st_q)
          S_IDLE: begin
            cnt_q <= '0;
            if (!rxd_s) st_q <= S_START;
          end
          S_START: begin
            if (cnt_q == CNT_MID) begin
              cnt_q <= '0;
              if (!rxd_s) begin
                st_q    <= S_DATA;
                start_o <= 1'b1;
              end else begin
                st_q <= S_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          S_DATA: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q <= '0;
              sh_q  <= {rxd_s, sh_q[DATA_W-1:1]};
              if (bit_q == BIT_LAST) begin
                bit_q <= '0;
                st_q  <= S_STOP;
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          S_STOP: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q  <= '0;
              st_q   <= S_IDLE;
              done_o <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_FULL);
  assign head_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= push_data_i;
        wr_q        <= ptr_inc(wr_q);
      end
      if (do_pop) rd_q <= ptr_inc(rd_q);
      unique case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic              start_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] char_i,
  input  logic              fifo_full_i,
  input  logic              pop_i,
  output logic              rx_en_o,
  output logic              flush_o,
  output logic              push_o,
  output logic [DATA_W-1:0] push_data_o,
  output logic              rts_o,
  output logic              ovr_o
);
  logic              en_cmd, dis_cmd, rst_cmd, rts_cmd;
  logic              kill;
  logic              start_ok, done_ok;
  logic              hold_v_q;
  logic [DATA_W-1:0] hold_d_q;
  logic              auto_q;

  assign en_cmd  = cmd_valid_i && (cmd_i == CMD_EN);
  assign dis_cmd = cmd_valid_i && (cmd_i == CMD_DIS);
  assign rst_cmd = cmd_valid_i && (cmd_i == CMD_RST);
  assign rts_cmd = cmd_valid_i && (cmd_i == CMD_RTS_ON);
  assign kill    = dis_cmd || rst_cmd;

  assign start_ok = start_i && rx_en_o && !kill;
  assign done_ok  = done_i && rx_en_o && !kill;

  assign flush_o     = rst_cmd;
  assign push_o      = !fifo_full_i && !kill && (hold_v_q || done_ok);
  assign push_data_o = hold_v_q ? hold_d_q : char_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rx_en_o <= 1'b0;
    else if (kill)    rx_en_o <= 1'b0;
    else if (en_cmd)  rx_en_o <= 1'b1;
  end

  // shift-stage holding slot and overrun
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q <= 1'b0;
      hold_d_q <= '0;
      ovr_o    <= 1'b0;
    end else begin
      if (rst_cmd) ovr_o <= 1'b0;
      else if (start_ok && hold_v_q) ovr_o <= 1'b1;

      if (kill) begin
        hold_v_q <= 1'b0;
      end else if (hold_v_q && (start_ok || !fifo_full_i)) begin
        hold_v_q <= 1'b0;
      end else if (done_ok && fifo_full_i) begin
        hold_v_q <= 1'b1;
        hold_d_q <= char_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rts_o  <= 1'b0;
      auto_q <= 1'b0;
    end else if (rst_cmd) begin
      rts_o  <= 1'b0;
      auto_q <= 1'b0;
    end else if (rts_cmd) begin
      rts_o  <= 1'b1;
      auto_q <= 1'b1;
    end else if (auto_q) begin
      if (pop_i)                          rts_o <= 1'b1;
      else if (start_ok && fifo_full_i)   rts_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_rts.sv
module uart_rx_rts
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int DEPTH  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              os_tick_i,
  input  logic              rxd_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic              irq_en_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rxrdy_o,
  output logic              ffull_o,
  output logic              ovr_o,
  output logic              irq_o,
  output logic              rts_o
);
  logic              rx_en_w;
  logic              start_w, done_w;
  logic [DATA_W-1:0] char_w;
  logic              flush_w, push_w;
  logic [DATA_W-1:0] push_data_w;
  logic              empty_w;
  logic              pop_w;

  assign rxrdy_o = !empty_w;
  assign pop_w   = rd_i && !empty_w;
  assign irq_o   = rxrdy_o && irq_en_i;

  uart_rx_deser #(.DATA_W(DATA_W), .OSR(OSR)) u_deser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (os_tick_i),
    .run_i   (rx_en_w),
    .rxd_i   (rxd_i),
    .start_o (start_w),
    .done_o  (done_w),
    .data_o  (char_w)
  );

  uart_rx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .start_i     (start_w),
    .done_i      (done_w),
    .char_i      (char_w),
    .fifo_full_i (ffull_o),
    .pop_i       (pop_w),
    .rx_en_o     (rx_en_w),
    .flush_o     (flush_w),
    .push_o      (push_w),
    .push_data_o (push_data_w),
    .rts_o       (rts_o),
    .ovr_o       (ovr_o)
  );

  uart_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_w),
    .push_i      (push_w),
    .push_data_i (push_data_w),
    .pop_i       (rd_i),
    .head_o      (rd_data_o),
    .empty_o     (empty_w),
    .full_o      (ffull_o)
  );
endmodule

// File: rtl/uart_rx_rts_chk.sv
module uart_rx_rts_chk
  import uart_rx_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic [2:0] cmd_i,
  input logic       irq_en_i,
  input logic       rd_i,
  input logic       rxrdy_o,
  input logic       ffull_o,
  input logic       ovr_o,
  input logic       irq_o,
  input logic       rts_o,
  input logic       rx_en
);
  a_r11_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == CMD_RST) |=> (!rxrdy_o && !ffull_o && !ovr_o && !rts_o && !irq_o));

  a_r4_full_implies_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ffull_o |-> rxrdy_o);

  a_r4_full_falls_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ffull_o) |-> ($past(rd_i) || $past(cmd_valid_i && cmd_i == CMD_RST)));

  a_r5_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en_i);

  a_r5_irq_drops_on_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rxrdy_o) |-> !irq_o);

  a_r6_rts_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rts_o) |-> ($past(cmd_valid_i && cmd_i == CMD_RTS_ON) || $past(rd_i && rxrdy_o)));

  a_r7_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !(cmd_valid_i && cmd_i == CMD_RST)) |=> ovr_o);

  a_r8_no_store_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en && !rxrdy_o) |=> !rxrdy_o);
endmodule

bind uart_rx_rts uart_rx_rts_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .irq_en_i    (irq_en_i),
  .rd_i        (rd_i),
  .rxrdy_o     (rxrdy_o),
  .ffull_o     (ffull_o),
  .ovr_o       (ovr_o),
  .irq_o       (irq_o),
  .rts_o       (rts_o),
  .rx_en       (rx_en_w)
);

// File: tb/uart_rx_rts_bench.sv
module uart_rx_rts_bench;
  localparam int DATA_W = 8;
  localparam int OSR    = 16;
  localparam int DEPTH  = 3;
  localparam int NVEC   = 5;
  // {irq_en, byte}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1, 8'h55}, {1'b0, 8'hA3}, {1'b1, 8'h00}, {1'b1, 8'hFF}, {1'b0, 8'h81}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b1;
  logic              rxd = 1'b1;
  logic              cmd_valid = 1'b0;
  logic [2:0]        cmd = 3'd0;
  logic              irq_en = 1'b0;
  logic              rd = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic              rxrdy, ffull, ovr, irq, rts;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  uart_rx_rts #(.DATA_W(DATA_W), .OSR(OSR), .DEPTH(DEPTH)) u_uart_rx_rts (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .os_tick_i   (tick),
    .rxd_i       (rxd),
    .cmd_valid_i (cmd_valid),
    .cmd_i       (cmd),
    .irq_en_i    (irq_en),
    .rd_i        (rd),
    .rd_data_o   (rd_data),
    .rxrdy_o     (rxrdy),
    .ffull_o     (ffull),
    .ovr_o       (ovr),
    .irq_o       (irq),
    .rts_o       (rts)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    rxd = 1'b0;
    repeat (OSR) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (OSR) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (OSR + 4) @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd = 3'd0;
  endtask

  task automatic read_chk(input string tag, input logic [7:0] exp);
    @(negedge clk);
    check({tag, " rxrdy"}, 32'(rxrdy), 32'(1));
    check({tag, " data"}, 32'(rd_data), 32'(exp));
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 rxrdy", 32'(rxrdy), 0);
    check("R1 ffull", 32'(ffull), 0);
    check("R1 ovr", 32'(ovr), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 rts", 32'(rts), 0);

    // R8: receiver disabled after reset, nothing stored
    send_byte(8'h5A);
    check("R8 disabled ignores frame", 32'(rxrdy), 0);

    issue(3'd1);
    check("R6 rts before cpu cmd", 32'(rts), 0);
    issue(3'd4);
    check("R6 rts cpu assert", 32'(rts), 1);

    // R2: short low glitch
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    check("R2 glitch rejected", 32'(rxrdy), 0);

    // R3 R4 R5 vector walk
    for (int i = 0; i < NVEC; i++) begin
      irq_en = VEC[i][8];
      send_byte(VEC[i][7:0]);
      check("R4 rxrdy set", 32'(rxrdy), 1);
      check("R5 irq follows enable", 32'(irq), 32'(VEC[i][8]));
      read_chk("R3 vec", VEC[i][7:0]);
      check("R4 rxrdy after drain", 32'(rxrdy), 0);
      check("R5 irq after drain", 32'(irq), 0);
    end
    irq_en = 1'b1;

    // R4 R6 R7: fill, park, recover
    send_byte(8'h11);
    send_byte(8'h22);
    check("R4 ffull low at 2", 32'(ffull), 0);
    send_byte(8'h33);
    check("R4 ffull at 3", 32'(ffull), 1);
    check("R6 rts still high", 32'(rts), 1);
    fork
      send_byte(8'h44);
      begin
        repeat (24) @(negedge clk);
        check("R6 rts drop on start when full", 32'(rts), 0);
      end
    join
    check("R7 no overrun on single park", 32'(ovr), 0);
    @(negedge clk);
    rd = 1'b1;
    check("R3 head", 32'(rd_data), 32'h11);
    @(negedge clk);
    rd = 1'b0;
    check("R6 rts back after read", 32'(rts), 1);
    repeat (2) @(negedge clk);
    check("R7 parked byte refills", 32'(ffull), 1);
    read_chk("R7 order b", 8'h22);
    read_chk("R7 order c", 8'h33);
    read_chk("R7 parked d", 8'h44);
    check("R4 empty", 32'(rxrdy), 0);

    // R7 overrun
    send_byte(8'hE1);
    send_byte(8'hE2);
    send_byte(8'hE3);
    send_byte(8'hE4);
    check("R7 ovr before second park", 32'(ovr), 0);
    send_byte(8'hE5);
    check("R7 ovr set", 32'(ovr), 1);
    read_chk("R7 ovr a", 8'hE1);
    read_chk("R7 ovr b", 8'hE2);
    read_chk("R7 ovr c", 8'hE3);
    read_chk("R7 overwritten by newer", 8'hE5);
    check("R7 empty after overrun", 32'(rxrdy), 0);
    check("R7 ovr sticky", 32'(ovr), 1);

    // R9 disable mid-frame
    fork
      send_byte(8'h3C);
      begin
        repeat (60) @(negedge clk);
        issue(3'd2);
      end
    join
    issue(3'd1);
    repeat (40) @(negedge clk);
    check("R9 mid-frame discarded", 32'(rxrdy), 0);

    // R8 queued bytes survive disable
    send_byte(8'h6D);
    issue(3'd2);
    send_byte(8'h7E);
    read_chk("R8 readable when off", 8'h6D);
    check("R8 no new while off", 32'(rxrdy), 0);
    issue(3'd1);

    // R10 disable with parked byte
    send_byte(8'hA1);
    send_byte(8'hA2);
    send_byte(8'hA3);
    send_byte(8'hA4);
    issue(3'd2);
    read_chk("R10 a", 8'hA1);
    read_chk("R10 b", 8'hA2);
    read_chk("R10 c", 8'hA3);
    check("R10 parked byte lost", 32'(rxrdy), 0);
    issue(3'd1);

    // R11 reset command
    send_byte(8'hC3);
    check("R11 pre rxrdy", 32'(rxrdy), 1);
    issue(3'd3);
    check("R11 rxrdy", 32'(rxrdy), 0);
    check("R11 ovr", 32'(ovr), 0);
    check("R11 irq", 32'(irq), 0);
    check("R11 rts", 32'(rts), 0);
    send_byte(8'hC4);
    check("R11 left disabled", 32'(rxrdy), 0);
    issue(3'd1);
    send_byte(8'hC5);
    check("R11 rts waits for cpu", 32'(rts), 0);
    read_chk("R11 after re-enable", 8'hC5);
    issue(3'd4);
    check("R11 rts re-armed", 32'(rts), 1);

    finish_run();
  end
endmodule